// File: doc/BRIEF.md
# Noise-Shaping Word-Length Reducer

This block shortens stereo 24-bit two's-complement audio samples to 16, 18 or 20 significant bits without plain truncation. Before each sample is requantised it gets triangular dither. It also gets the weighted sum of that channel's last ten quantisation errors, taken through a host-loadable FIR. This pushes the requantisation noise towards frequencies where it is less audible. Left and right share one coefficient set and one dither source, and each channel keeps its own error history.

A sample is offered with a one-cycle strobe, a channel flag and the word-length setting. A small state machine handles it. `ST_IDLE` accepts the strobe and goes to `ST_ACCUM`. `ST_ACCUM` spends one cycle per tap on a single multiply-accumulate. It stays there until the last tap and then moves to `ST_QUANT`. `ST_QUANT` adds dither, removes the feedback, rounds, saturates and updates the error history, then always returns to `ST_IDLE`. The result leaves left-aligned in a 24-bit field, a fixed number of cycles after the strobe. A fourth word-length setting passes samples through untouched and clears both histories.

Top module: `nshape_reducer`

## Requirements
- R1: `in_chan` = 0 marks a left sample and 1 a right sample. Each channel keeps a separate error history. `out_chan` repeats the channel of the sample being output.
- R2: `wl_sel` is captured with the accepted strobe and selects the output length: 0 gives 16 bits, 1 gives 18 bits, 2 gives 20 bits and 3 gives pass-through. The number of dropped bits is D = 24 − length.
- R3: In the three reducing settings, the D low bits of `out_sample` are zero. The kept bits are the quantised word, left-aligned.
- R4: The quantiser target is v = x + d − floor(S / 2^14), where S is the sum over k = 0..9 of c[k]·h[k] and h[0] is the channel's most recent error. The quantised value is q = floor((v + 2^(D−1)) / 2^D). The new error q·2^D − v is clamped to [−2048, 2047] and pushed into that channel's history. The output is q·2^D.
- R5: q saturates to [−2^(L−1), 2^(L−1)−1], where L is the output length, instead of wrapping.
- R6: Dither comes from two 16-bit right-shifting Galois LFSRs. Their feedback masks are 0xB400 and 0xD008, and they reset to 0xACE1 and 0x1D2B. Dither d equals the D low bits of the first LFSR minus the D low bits of the second. Both LFSRs step once per accepted sample, after their value has been used.
- R7: There are ten signed 16-bit Q2.14 coefficients, written through `coef_we`/`coef_addr`/`coef_wdata`. Address k sets c[k]. Addresses 10 to 15 are ignored.
- R8: With `wl_sel` = 3, `out_sample` equals the input sample exactly, and the error histories of both channels are cleared to zero.
- R9: `out_valid` is a one-cycle pulse. It is seen after the eleventh rising edge that follows the edge accepting the strobe.
- R10: A strobe that arrives while a sample is still being processed has no effect. It produces no output, does not step the dither and does not touch any history.
- R11: Reset sets `out_valid` and `out_sample` to zero, sets all coefficients and histories to zero and reseeds both LFSRs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_chan | input | 1 | Channel flag, 0 left, 1 right |
| in_sample | input | 24 | Signed input sample |
| wl_sel | input | 2 | Output word-length setting |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 4 | Coefficient index |
| coef_wdata | input | 16 | Coefficient value, Q2.14 |
| out_valid | output | 1 | Result strobe |
| out_chan | output | 1 | Channel of the result |
| out_sample | output | 24 | Reduced, left-aligned sample |

## Verification
With all coefficients at zero, a vector table drives mid-scale, negative and zero samples at every length. This separates the dither sequence and the rounding from the error feedback. Full-scale positive and negative samples separate saturation from wrap-around. Interleaved left and right runs with nonzero coefficients show whether the two histories are kept apart and whether the taps line up with the right errors. A run driven hard into saturation with coefficients near +2 produces errors large enough to hit the clamp, and a zero sample afterwards exposes the clamped history. A strobe injected mid-process, a pass-through sample between shaped ones, and a mid-run reset show whether a stray strobe, a history clear or a reseed leaves a visible trace in later outputs.

// File: rtl/nsq_pkg.sv
package nsq_pkg;

    typedef enum logic [1:0] {
        WL_16   = 2'd0,
        WL_18   = 2'd1,
        WL_20   = 2'd2,
        WL_PASS = 2'd3
    } wlen_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_QUANT = 2'd2
    } nsq_state_e;

    // Number of low bits discarded for a given setting of a dw-bit input.
    function automatic int drop_bits(input wlen_e w, input int dw);
        case (w)
            WL_16:   return dw - 16;
            WL_18:   return dw - 18;
            WL_20:   return dw - 20;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/nsq_dither.sv
module nsq_dither
    import nsq_pkg::*;
#(
    parameter int            LW     = 16,
    parameter int            DW     = 24,
    parameter int            DTH_W  = 10,
    parameter logic [LW-1:0] POLY_A = 16'hB400,
    parameter logic [LW-1:0] POLY_B = 16'hD008,
    parameter logic [LW-1:0] SEED_A = 16'hACE1,
    parameter logic [LW-1:0] SEED_B = 16'h1D2B
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  wlen_e                   wl,
    output logic signed [DTH_W-1:0] dither
);
    localparam int MAXDROP = DTH_W - 2;

    logic [LW-1:0]      lfsr_a;
    logic [LW-1:0]      lfsr_b;
    logic [MAXDROP-1:0] keep_mask;
    logic [DTH_W-1:0]   ra;
    logic [DTH_W-1:0]   rb;

    function automatic logic [LW-1:0] lfsr_next(input logic [LW-1:0] s,
                                                input logic [LW-1:0] poly);
        return (s >> 1) ^ (s[0] ? poly : '0);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_a <= SEED_A;
            lfsr_b <= SEED_B;
        end else if (step) begin
            lfsr_a <= lfsr_next(lfsr_a, POLY_A);
            lfsr_b <= lfsr_next(lfsr_b, POLY_B);
        end
    end

    always_comb begin
        for (int i = 0; i < MAXDROP; i++) begin
            keep_mask[i] = (i < drop_bits(wl, DW));
        end
        ra     = {2'b00, lfsr_a[MAXDROP-1:0] & keep_mask};
        rb     = {2'b00, lfsr_b[MAXDROP-1:0] & keep_mask};
        dither = $signed(ra) - $signed(rb);
    end

    AST_LFSR_ALIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (lfsr_a != '0) && (lfsr_b != '0)); // R6

endmodule

// File: rtl/nsq_coef_bank.sv
module nsq_coef_bank #(
    parameter int TAPS = 10,
    parameter int CW   = 16,
    parameter int AW   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [AW-1:0]        wr_addr,
    input  logic signed [CW-1:0] wr_data,
    input  logic [AW-1:0]        rd_idx,
    output logic signed [CW-1:0] rd_coef
);
    logic signed [CW-1:0] coef [TAPS];
    logic                 wr_hit;

    assign wr_hit = we && (int'(wr_addr) < TAPS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < TAPS; k++) coef[k] <= '0;
        end else if (wr_hit) begin
            coef[wr_addr] <= wr_data;
        end
    end

    assign rd_coef = coef[rd_idx];

    AST_COEF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (coef[$past(wr_addr)] == $past(wr_data))); // R7

endmodule

// File: rtl/nsq_err_hist.sv
module nsq_err_hist #(
    parameter int TAPS = 10,
    parameter int EW   = 12,
    parameter int AW   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic                 clear,
    input  logic                 wr_chan,
    input  logic signed [EW-1:0] wr_err,
    input  logic                 rd_chan,
    input  logic [AW-1:0]        rd_idx,
    output logic signed [EW-1:0] rd_err
);
    logic signed [EW-1:0] hist [2][TAPS];
    logic                 all_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++)
                for (int k = 0; k < TAPS; k++) hist[c][k] <= '0;
        end else if (clear) begin
            for (int c = 0; c < 2; c++)
                for (int k = 0; k < TAPS; k++) hist[c][k] <= '0;
        end else if (push) begin
            for (int k = TAPS - 1; k > 0; k--) hist[wr_chan][k] <= hist[wr_chan][k-1];
            hist[wr_chan][0] <= wr_err;
        end
    end

    assign rd_err = hist[rd_chan][rd_idx];

    always_comb begin
        all_zero = 1'b1;
        for (int c = 0; c < 2; c++)
            for (int k = 0; k < TAPS; k++)
                if (hist[c][k] != '0) all_zero = 1'b0;
    end

    AST_HIST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> all_zero); // R8

endmodule

// File: rtl/nsq_quant.sv
module nsq_quant
    import nsq_pkg::*;
#(
    parameter int DW = 24,
    parameter int VW = 27,
    parameter int EW = 12
) (
    input  logic signed [VW-1:0] target,
    input  wlen_e                wl,
    output logic [DW-1:0]        word,
    output logic signed [EW-1:0] err
);
    localparam logic signed [VW-1:0] ONE  = VW'(1);
    localparam logic signed [VW-1:0] EMAX = (ONE <<< (EW - 1)) - ONE;
    localparam logic signed [VW-1:0] EMIN = -(ONE <<< (EW - 1));

    int                   sh;
    logic signed [VW-1:0] half;
    logic signed [VW-1:0] q;
    logic signed [VW-1:0] qmax;
    logic signed [VW-1:0] qmin;
    logic signed [VW-1:0] qs;
    logic signed [VW-1:0] qv;
    logic signed [VW-1:0] ediff;

    always_comb begin
        sh    = drop_bits(wl, DW);
        half  = (sh == 0) ? '0 : (ONE <<< (sh - 1));
        q     = (target + half) >>> sh;
        qmax  = (ONE <<< (DW - 1 - sh)) - ONE;
        qmin  = -(ONE <<< (DW - 1 - sh));
        if (q > qmax)      qs = qmax;
        else if (q < qmin) qs = qmin;
        else               qs = q;
        qv    = qs <<< sh;
        ediff = qv - target;
        if (ediff > EMAX)      err = EW'(EMAX);
        else if (ediff < EMIN) err = EW'(EMIN);
        else                   err = EW'(ediff);
        word  = qv[DW-1:0];
    end

endmodule

// File: rtl/nshape_reducer.sv
module nshape_reducer
    import nsq_pkg::*;
#(
    parameter int DW    = 24,
    parameter int CW    = 16,
    parameter int CFRAC = 14,
    parameter int EW    = 12,
    parameter int TAPS  = 10,
    parameter int AW    = $clog2(TAPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_chan,
    input  logic [DW-1:0] in_sample,
    input  logic [1:0]    wl_sel,
    input  logic          coef_we,
    input  logic [AW-1:0] coef_addr,
    input  logic [CW-1:0] coef_wdata,
    output logic          out_valid,
    output logic          out_chan,
    output logic [DW-1:0] out_sample
);
    localparam int MAXDROP = DW - 16;
    localparam int DTH_W   = MAXDROP + 2;
    localparam int ACC_W   = CW + EW + $clog2(TAPS);
    localparam int VW      = DW + 3;
    localparam int LAT     = TAPS + 1;
    localparam int LCW     = $clog2(LAT + 1);

    nsq_state_e state, nxt;

    logic                    accept;
    logic [AW-1:0]           tap_idx;
    logic signed [DW-1:0]    x_q;
    logic                    chan_q;
    wlen_e                   wl_q;
    logic signed [DTH_W-1:0] dither;
    logic signed [DTH_W-1:0] dither_q;
    logic signed [ACC_W-1:0] acc;
    logic signed [CW-1:0]    rd_coef;
    logic signed [EW-1:0]    rd_err;
    logic signed [CW+EW-1:0] prod;
    logic signed [ACC_W-1:0] fb_full;
    logic signed [VW-1:0]    target;
    logic [DW-1:0]           q_word;
    logic signed [EW-1:0]    q_err;
    logic                    hist_push;
    logic                    hist_clear;

    assign accept = (state == ST_IDLE) && in_valid;

    // ---------------- sub-blocks ----------------
    nsq_dither #(
        .LW    (16),
        .DW    (DW),
        .DTH_W (DTH_W)
    ) u_dither (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (accept),
        .wl     (wlen_e'(wl_sel)),
        .dither (dither)
    );

    nsq_coef_bank #(
        .TAPS (TAPS),
        .CW   (CW),
        .AW   (AW)
    ) u_coef (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (coef_we),
        .wr_addr (coef_addr),
        .wr_data (coef_wdata),
        .rd_idx  (tap_idx),
        .rd_coef (rd_coef)
    );

    nsq_err_hist #(
        .TAPS (TAPS),
        .EW   (EW),
        .AW   (AW)
    ) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (hist_push),
        .clear   (hist_clear),
        .wr_chan (chan_q),
        .wr_err  (q_err),
        .rd_chan (chan_q),
        .rd_idx  (tap_idx),
        .rd_err  (rd_err)
    );

    nsq_quant #(
        .DW (DW),
        .VW (VW),
        .EW (EW)
    ) u_quant (
        .target (target),
        .wl     (wl_q),
        .word   (q_word),
        .err    (q_err)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (in_valid) nxt = ST_ACCUM;
            ST_ACCUM: if (tap_idx == AW'(TAPS - 1)) nxt = ST_QUANT;
            ST_QUANT: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // ---------------- datapath ----------------
    assign prod       = rd_coef * rd_err;
    assign fb_full    = acc >>> CFRAC;
    assign target     = VW'(x_q) + VW'(dither_q) - VW'(fb_full);
    assign hist_push  = (state == ST_QUANT) && (wl_q != WL_PASS);
    assign hist_clear = (state == ST_QUANT) && (wl_q == WL_PASS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q      <= '0;
            chan_q   <= 1'b0;
            wl_q     <= WL_16;
            dither_q <= '0;
            acc      <= '0;
            tap_idx  <= '0;
        end else if (accept) begin
            x_q      <= in_sample;
            chan_q   <= in_chan;
            wl_q     <= wlen_e'(wl_sel);
            dither_q <= dither;
            acc      <= '0;
            tap_idx  <= '0;
        end else if (state == ST_ACCUM) begin
            acc <= acc + ACC_W'(prod);
            if (tap_idx != AW'(TAPS - 1)) tap_idx <= tap_idx + 1'b1;
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_chan   <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= (state == ST_QUANT);
            if (state == ST_QUANT) begin
                out_chan   <= chan_q;
                out_sample <= (wl_q == WL_PASS) ? x_q : q_word;
            end
        end
    end

    // ---------------- checks ----------------
    logic [LCW-1:0] lat_cnt;
    logic [DW-1:0]  low_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    lat_cnt <= '0;
        else if (accept)                               lat_cnt <= LCW'(1);
        else if (lat_cnt != '0 && lat_cnt < LCW'(LAT)) lat_cnt <= lat_cnt + 1'b1;
        else                                           lat_cnt <= '0;
    end

    always_comb begin
        for (int i = 0; i < DW; i++) low_mask[i] = (i < drop_bits(wl_q, DW));
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(lat_cnt) == LCW'(LAT))); // R9

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R9

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_sample & low_mask) == '0)); // R3

    AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ($stable(x_q) && $stable(chan_q))); // R10

endmodule

// File: tb/nshape_reducer_tb.sv
`timescale 1ns/1ps
module nshape_reducer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_chan = 1'b0;
    logic [23:0] in_sample = '0;
    logic [1:0]  wl_sel = '0;
    logic        coef_we = 1'b0;
    logic [3:0]  coef_addr = '0;
    logic [15:0] coef_wdata = '0;
    logic        out_valid;
    logic        out_chan;
    logic [23:0] out_sample;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    nshape_reducer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
        .in_sample(in_sample), .wl_sel(wl_sel), .coef_we(coef_we),
        .coef_addr(coef_addr), .coef_wdata(coef_wdata), .out_valid(out_valid),
        .out_chan(out_chan), .out_sample(out_sample)
    );

    // ---------------- reference model from the requirements ----------------
    int m_coef [10];
    int m_hist [2][10];
    int m_la, m_lb;

    task automatic model_reset();
        for (int k = 0; k < 10; k++) begin
            m_coef[k] = 0; m_hist[0][k] = 0; m_hist[1][k] = 0;
        end
        m_la = 'hACE1; m_lb = 'h1D2B;
    endtask

    function automatic int lfsr_step(input int s, input int poly);
        return ((s >> 1) ^ (((s & 1) != 0) ? poly : 0)) & 'hFFFF;
    endfunction

    task automatic model_step(input int wl, input int ch, input int x, output int res);
        int s, d, acc, fb, v, q, qmax, qmin, qv, e;
        s = (wl == 3) ? 0 : 8 - 2 * wl;
        d = (m_la & ((1 << s) - 1)) - (m_lb & ((1 << s) - 1));
        m_la = lfsr_step(m_la, 'hB400);
        m_lb = lfsr_step(m_lb, 'hD008);
        if (wl == 3) begin
            for (int k = 0; k < 10; k++) begin m_hist[0][k] = 0; m_hist[1][k] = 0; end
            res = x;
            return;
        end
        acc = 0;
        for (int k = 0; k < 10; k++) acc += m_coef[k] * m_hist[ch][k];
        fb = acc >>> 14;
        v  = x + d - fb;
        q  = (v + (1 << (s - 1))) >>> s;
        qmax = (1 << (23 - s)) - 1;
        qmin = -(1 << (23 - s));
        if (q > qmax) q = qmax;
        if (q < qmin) q = qmin;
        qv = q * (1 << s);
        e  = qv - v;
        if (e > 2047)  e = 2047;
        if (e < -2048) e = -2048;
        for (int k = 9; k > 0; k--) m_hist[ch][k] = m_hist[ch][k-1];
        m_hist[ch][0] = e;
        res = qv;
    endtask

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic write_coef(input int addr, input int val);
        @(negedge clk);
        coef_we = 1'b1; coef_addr = 4'(addr); coef_wdata = 16'(val);
        @(negedge clk);
        coef_we = 1'b0;
        if (addr < 10) m_coef[addr] = int'($signed(16'(val)));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R11 out_valid in reset", int'(out_valid), 0);
        check(out_sample == '0, "R11 out_sample in reset", int'(out_sample), 0);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Feed one sample, check latency, data, channel and cleared low bits.
    task automatic send(input int wl, input int ch, input int x, input bit use_exp,
                        input int exp_v, input bit glitch, input string tag);
        int mexp, expv, act, early, late_ok, s;
        logic [23:0] got;
        logic got_ch;
        model_step(wl, ch, x, mexp);
        expv = use_exp ? exp_v : mexp;
        s = (wl == 3) ? 0 : 8 - 2 * wl;
        @(negedge clk);
        in_valid = 1'b1; wl_sel = 2'(wl); in_chan = ch[0]; in_sample = 24'(x);
        @(negedge clk);
        in_valid = 1'b0; wl_sel = 2'(wl + 1); in_sample = ~in_sample; in_chan = ~in_chan;
        early = 0; got = '0; got_ch = 1'b0; late_ok = 0;
        for (int i = 1; i <= 11; i++) begin
            if (glitch && i == 3) begin
                in_valid = 1'b1; in_sample = 24'h5A5A5A; wl_sel = 2'd0;
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
            if (i < 11 && out_valid) early++;
            if (i == 11) begin
                late_ok = out_valid ? 1 : 0;
                got = out_sample; got_ch = out_chan;
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
        if (out_valid) early++;
        check(early == 0 && late_ok == 1, {"R9 R10 latency ", tag}, early, 0);
        act = int'($signed(got));
        check(act == expv, {"R4 R6 data ", tag}, act, expv);
        check(got_ch == ch[0], {"R1 channel ", tag}, int'(got_ch), ch);
        check((int'(got) & ((1 << s) - 1)) == 0, {"R2 R3 low bits ", tag},
              int'(got) & ((1 << s) - 1), 0);
    endtask

    // ---------------- vector table ----------------
    typedef struct packed {
        logic [1:0]  wl;
        logic        ch;
        logic [23:0] x;
        logic        has_exp;
        logic [23:0] exp_v;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 24'h123456, 1'b0, 24'h000000},   // R4 R6 16-bit
        '{2'd1, 1'b1, 24'hFFFC18, 1'b0, 24'h000000},   // R4 18-bit negative
        '{2'd2, 1'b0, 24'h000000, 1'b0, 24'h000000},   // R6 20-bit zero
        '{2'd0, 1'b0, 24'h7FFFFF, 1'b1, 24'h7FFF00},   // R5 top, 16-bit
        '{2'd0, 1'b1, 24'h800000, 1'b1, 24'h800000},   // R5 bottom, 16-bit
        '{2'd1, 1'b0, 24'h7FFFFF, 1'b1, 24'h7FFFC0},   // R5 top, 18-bit
        '{2'd2, 1'b1, 24'h800000, 1'b1, 24'h800000},   // R5 bottom, 20-bit
        '{2'd3, 1'b0, 24'hABCDEF, 1'b1, 24'hABCDEF},   // R8 pass-through
        '{2'd3, 1'b1, 24'h000001, 1'b1, 24'h000001},   // R8 pass-through
        '{2'd0, 1'b1, 24'h000080, 1'b0, 24'h000000}    // R4 half LSB
    };

    // ---------------- watchdog ----------------
    initial begin
        #(200000 * 20);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // ---------------- main sequence ----------------
    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R11 reset out_valid", int'(out_valid), 0);
        check(out_sample == '0, "R11 reset out_sample", int'(out_sample), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            send(int'(VECS[i].wl), int'(VECS[i].ch), int'($signed(VECS[i].x)),
                 VECS[i].has_exp, int'($signed(VECS[i].exp_v)), 1'b0, $sformatf("vec%0d", i));
        end

        // R7: load shaping taps, one out-of-range address
        write_coef(0, 16384);
        write_coef(1, -8192);
        write_coef(9, 4096);
        write_coef(12, 'h7FFF);
        for (int i = 0; i < 8; i++) begin
            send((i < 4) ? 0 : 1, i % 2, i * 123457 - 400000, 1'b0, 0, 1'b0,
                 $sformatf("R1 R7 shaped%0d", i));
        end

        // R10: stray strobe mid-process, then follow-up must still track
        send(0, 0, 300000, 1'b0, 0, 1'b1, "R10 glitch");
        send(0, 0, -300000, 1'b0, 0, 1'b0, "R10 after glitch");

        // R8: pass-through clears both histories
        send(3, 0, 24'h00F00D, 1'b1, 24'h00F00D, 1'b0, "R8 pass");
        send(0, 1, 777777, 1'b0, 0, 1'b0, "R8 after clear");

        // R4 R5: drive errors into the clamp
        for (int k = 0; k < 10; k++) write_coef(k, 'h7FFF);
        for (int i = 0; i < 12; i++) begin
            send(0, 0, 'h7FFFFF, 1'b1, 'h7FFF00, 1'b0, $sformatf("R5 sat%0d", i));
        end
        send(0, 0, 0, 1'b0, 0, 1'b0, "R4 clamp");

        // R11: reset mid-run clears taps, histories and dither
        do_reset();
        send(0, 0, 1234567, 1'b0, 0, 1'b0, "R11 after reset");
        send(1, 1, -7654321, 1'b0, 0, 1'b0, "R11 after reset 2");

        finish_run();
    end

endmodule